// File: doc/BRIEF.md
# Prioritized Auto-Masking Interrupt Controller

This block gathers 64 level-sensitive interrupt lines and hands them out to 4 processors through a small register window. Each line has three controls: an enable-blocking mask bit, a software request bit that acts as if the line's input were high, and a routing register naming the processors that may take it. A line is live when its input or its software request is set and its mask is clear. Each processor sees only the live lines routed to it.

A processor services interrupts by reading its event register. The read returns the lowest-numbered live line routed to that processor, tagged as a hardware event. In the same access it sets that line's mask bit, so the read also acknowledges the line. Software unmasks the line again when it has finished with it. The bus is a plain single-cycle read/write port. A sideband carries the index of the processor making the access, and that index selects which event register a read returns.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every software request bit is 0, and every routing register holds 1 (processor 0 only).
- R2: The event word at offset 0x2004 carries the event kind in bits 31:16 and the line number in bits 15:0. Kind 1 means a hardware line. When the reading processor has no live routed line, the word is all zeros.
- R3: A read of 0x2004 that returns a line sets that line's mask bit on the same clock edge, so the next read returns the next live line or zero.
- R4: When several live lines are routed to the reader, the lowest-numbered one is returned first.
- R5: A line is pending when its input is high or its software request bit is set. Writing a 1 to bit n&31 of the word at 0x4000 + 4*(n>>5) sets the request bit of line n. Writing a 1 to the same bit of the word at 0x4080 + 4*(n>>5) clears it. Zero bits have no effect. Reading either word returns the current request bits.
- R6: Writing a 1 to bit n&31 of the word at 0x4100 + 4*(n>>5) sets the mask bit of line n. Writing a 1 to the same bit of the word at 0x4180 + 4*(n>>5) clears it. Zero bits have no effect. Reading either word returns the current mask bits.
- R7: The routing register of line n sits at 0x3000 + 4*n, with bit c standing for processor c. A line is returned only to processors whose bit is set. The register reads back its stored value.
- R8: Offset 0x0004 reads the number of lines (64). Offset 0x2000 reads the index of the accessing processor.
- R9: Reads of any other offset return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 64 | Level-sensitive interrupt inputs |
| bus_cpu | input | 2 | Index of the processor making the access |
| bus_addr | input | 16 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, acts on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; rdata is valid in the same cycle |
| bus_rdata | output | 32 | Read data, zero when no read is active |

## Verification
A stale or corrupted mask bit is visible on the very next event read. A line that should have been acknowledged comes back a second time, or a line that was unmasked never appears, so a missing mask update shows up one access later. A wrong routing bit or a broken priority scan makes a read return the wrong line number, or return it to the wrong processor, in that same read. The routing, mask and request state can also be read back directly through their own offsets, which separates a storage fault from a selection fault.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    localparam logic [15:0] OFF_INFO   = 16'h0004;
    localparam logic [15:0] OFF_WHOAMI = 16'h2000;
    localparam logic [15:0] OFF_EVENT  = 16'h2004;
    localparam logic [15:0] OFF_ROUTE  = 16'h3000;
    localparam logic [15:0] OFF_REQSET = 16'h4000;
    localparam logic [15:0] OFF_REQCLR = 16'h4080;
    localparam logic [15:0] OFF_MSKSET = 16'h4100;
    localparam logic [15:0] OFF_MSKCLR = 16'h4180;

    localparam logic [15:0] EVT_KIND_HW = 16'd1;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_INFO,
        ACC_WHOAMI,
        ACC_EVENT,
        ACC_ROUTE,
        ACC_REQSET,
        ACC_REQCLR,
        ACC_MSKSET,
        ACC_MSKCLR
    } acc_kind_t;

    typedef struct packed {
        acc_kind_t   kind;
        logic [15:0] index;
    } acc_t;

    typedef struct packed {
        logic [15:0] kind;
        logic [15:0] num;
    } evt_word_t;

    function automatic logic in_bank(input int a, input logic [15:0] base, input int count);
        return (a >= int'(base)) && (a < int'(base) + 4 * count);
    endfunction

    // Maps a byte offset to a register kind and a word or line index.
    // Line-indexed windows must not overlap: lines <= 1024.
    function automatic acc_t decode_addr(input logic [15:0] addr,
                                         input int nwords, input int nlines);
        acc_t r;
        int   a;
        a       = int'(addr);
        r.kind  = ACC_NONE;
        r.index = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr == OFF_INFO)
                r.kind = ACC_INFO;
            else if (addr == OFF_WHOAMI)
                r.kind = ACC_WHOAMI;
            else if (addr == OFF_EVENT)
                r.kind = ACC_EVENT;
            else if (in_bank(a, OFF_ROUTE, nlines)) begin
                r.kind  = ACC_ROUTE;
                r.index = 16'((a - int'(OFF_ROUTE)) >> 2);
            end else if (in_bank(a, OFF_REQSET, nwords)) begin
                r.kind  = ACC_REQSET;
                r.index = 16'((a - int'(OFF_REQSET)) >> 2);
            end else if (in_bank(a, OFF_REQCLR, nwords)) begin
                r.kind  = ACC_REQCLR;
                r.index = 16'((a - int'(OFF_REQCLR)) >> 2);
            end else if (in_bank(a, OFF_MSKSET, nwords)) begin
                r.kind  = ACC_MSKSET;
                r.index = 16'((a - int'(OFF_MSKSET)) >> 2);
            end else if (in_bank(a, OFF_MSKCLR, nwords)) begin
                r.kind  = ACC_MSKCLR;
                r.index = 16'((a - int'(OFF_MSKCLR)) >> 2);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
    import prio_irq_pkg::*;
#(
    parameter  int NL = 64,
    parameter  int NC = 4,
    localparam int LW = $clog2(NL)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  acc_t                  acc,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  ack_valid,
    input  logic [LW-1:0]         ack_line,
    output logic [NL-1:0]         mask_q,
    output logic [NL-1:0]         req_q,
    output logic [NL-1:0][NC-1:0] route_q
);

    generate
        for (genvar l = 0; l < NL; l++) begin : g_line
            localparam int WI = l / DATA_W;
            localparam int BI = l % DATA_W;

            logic word_hit;
            logic bit_one;
            assign word_hit = wr && (acc.index == 16'(WI));
            assign bit_one  = wdata[BI];

            always_ff @(posedge clk) begin
                if (rst) begin
                    mask_q[l] <= 1'b1;
                end else if (ack_valid && ack_line == LW'(l)) begin
                    mask_q[l] <= 1'b1;
                end else if (word_hit && bit_one && acc.kind == ACC_MSKSET) begin
                    mask_q[l] <= 1'b1;
                end else if (word_hit && bit_one && acc.kind == ACC_MSKCLR) begin
                    mask_q[l] <= 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    req_q[l] <= 1'b0;
                end else if (word_hit && bit_one && acc.kind == ACC_REQSET) begin
                    req_q[l] <= 1'b1;
                end else if (word_hit && bit_one && acc.kind == ACC_REQCLR) begin
                    req_q[l] <= 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    route_q[l] <= NC'(1);
                end else if (wr && acc.kind == ACC_ROUTE && acc.index == 16'(l)) begin
                    route_q[l] <= wdata[NC-1:0];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick
    import prio_irq_pkg::*;
#(
    parameter  int NL = 64,
    localparam int LW = $clog2(NL)
) (
    input  logic [NL-1:0] elig,
    output evt_word_t     evt,
    output logic          found,
    output logic [LW-1:0] idx
);

    // Scan from the top down so the lowest eligible line is kept last.
    always_comb begin
        idx = '0;
        for (int i = NL - 1; i >= 0; i--) begin
            if (elig[i]) idx = LW'(i);
        end
    end

    assign found    = |elig;
    assign evt.kind = found ? EVT_KIND_HW : 16'd0;
    assign evt.num  = found ? 16'(idx) : 16'd0;

endmodule

// File: rtl/prio_irq_rdmux.sv
module prio_irq_rdmux
    import prio_irq_pkg::*;
#(
    parameter  int NL = 64,
    parameter  int NC = 4,
    localparam int NW = NL / DATA_W,
    localparam int CW = $clog2(NC)
) (
    input  logic                  rd,
    input  acc_t                  acc,
    input  logic [CW-1:0]         cpu,
    input  logic [NL-1:0]         mask_q,
    input  logic [NL-1:0]         req_q,
    input  logic [NL-1:0][NC-1:0] route_q,
    input  evt_word_t [NC-1:0]    evts,
    output logic [DATA_W-1:0]     rdata
);

    logic [DATA_W-1:0] mask_word;
    logic [DATA_W-1:0] req_word;
    logic [NC-1:0]     route_sel;
    evt_word_t         evt_sel;

    always_comb begin
        mask_word = '0;
        req_word  = '0;
        for (int w = 0; w < NW; w++) begin
            if (acc.index == 16'(w)) begin
                mask_word = mask_q[w*DATA_W +: DATA_W];
                req_word  = req_q[w*DATA_W +: DATA_W];
            end
        end
    end

    always_comb begin
        route_sel = '0;
        for (int l = 0; l < NL; l++) begin
            if (acc.index == 16'(l)) route_sel = route_q[l];
        end
    end

    always_comb begin
        evt_sel = '0;
        for (int c = 0; c < NC; c++) begin
            if (cpu == CW'(c)) evt_sel = evts[c];
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (acc.kind)
                ACC_INFO:               rdata = DATA_W'(NL);
                ACC_WHOAMI:             rdata = DATA_W'(cpu);
                ACC_EVENT:              rdata = evt_sel;
                ACC_ROUTE:              rdata = DATA_W'(route_sel);
                ACC_REQSET, ACC_REQCLR: rdata = req_word;
                ACC_MSKSET, ACC_MSKCLR: rdata = mask_word;
                default:                rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter  int NUM_LINES = 64,
    parameter  int NUM_CPUS  = 4,
    localparam int CPU_W     = $clog2(NUM_CPUS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic [CPU_W-1:0]     bus_cpu,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_rd,
    output logic [DATA_W-1:0]    bus_rdata
);

    localparam int NUM_WORDS = NUM_LINES / DATA_W;
    localparam int LINE_W    = $clog2(NUM_LINES);

    acc_t                              acc;
    logic [NUM_LINES-1:0]              mask_q;
    logic [NUM_LINES-1:0]              req_q;
    logic [NUM_LINES-1:0][NUM_CPUS-1:0] route_q;
    logic [NUM_LINES-1:0]              live;
    evt_word_t [NUM_CPUS-1:0]          evts;
    logic [NUM_CPUS-1:0]               found;
    logic [NUM_CPUS-1:0][LINE_W-1:0]   pick_idx;
    logic                              ack_valid;
    logic [LINE_W-1:0]                 ack_line;

    assign acc  = decode_addr(bus_addr, NUM_WORDS, NUM_LINES);
    assign live = (line_in | req_q) & ~mask_q;

    generate
        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
            logic [NUM_LINES-1:0] elig;
            for (genvar l = 0; l < NUM_LINES; l++) begin : g_el
                assign elig[l] = live[l] & route_q[l][c];
            end
            prio_irq_pick #(.NL(NUM_LINES)) u_pick (
                .elig  (elig),
                .evt   (evts[c]),
                .found (found[c]),
                .idx   (pick_idx[c])
            );
        end
    endgenerate

    // Event read acknowledges the delivered line by masking it.
    always_comb begin
        ack_valid = 1'b0;
        ack_line  = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (bus_cpu == CPU_W'(c)) begin
                ack_valid = bus_rd && (acc.kind == ACC_EVENT) && found[c];
                ack_line  = pick_idx[c];
            end
        end
    end

    prio_irq_regs #(.NL(NUM_LINES), .NC(NUM_CPUS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .acc       (acc),
        .wdata     (bus_wdata),
        .ack_valid (ack_valid),
        .ack_line  (ack_line),
        .mask_q    (mask_q),
        .req_q     (req_q),
        .route_q   (route_q)
    );

    prio_irq_rdmux #(.NL(NUM_LINES), .NC(NUM_CPUS)) u_rdmux (
        .rd      (bus_rd),
        .acc     (acc),
        .cpu     (bus_cpu),
        .mask_q  (mask_q),
        .req_q   (req_q),
        .route_q (route_q),
        .evts    (evts),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
    import prio_irq_pkg::*;
#(
    parameter  int NL = 64,
    parameter  int NC = 4,
    localparam int LW = $clog2(NL),
    localparam int CW = $clog2(NC)
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NL-1:0]         line_in,
    input logic [CW-1:0]         bus_cpu,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_rd,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic [NL-1:0]         mask_q,
    input logic [NL-1:0]         req_q,
    input logic [NL-1:0][NC-1:0] route_q
);

    logic          evt_rd;
    logic          evt_hit;
    logic [LW-1:0] got;
    logic [NL-1:0] col_live;
    logic [NL-1:0] below;

    assign evt_rd  = bus_rd && (bus_addr == OFF_EVENT);
    assign evt_hit = evt_rd && (bus_rdata != '0);
    assign got     = bus_rdata[LW-1:0];
    assign below   = ({{(NL-1){1'b0}}, 1'b1} << got) - 1'b1;

    always_comb begin
        for (int l = 0; l < NL; l++) begin
            col_live[l] = (line_in[l] | req_q[l]) & ~mask_q[l] & route_q[l][bus_cpu];
        end
    end

    AST_RESET_MASKED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&mask_q && req_q == '0)); // R1

    AST_EVT_FORMAT: assert property (@(posedge clk) disable iff (rst)
        evt_rd |-> (bus_rdata == '0 ||
                    (bus_rdata[31:16] == EVT_KIND_HW && bus_rdata[15:0] < 16'(NL)))); // R2

    AST_EVT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (evt_rd && bus_rdata == '0) |-> (col_live == '0)); // R2

    AST_ACK_OPEN: assert property (@(posedge clk) disable iff (rst)
        evt_hit |-> !mask_q[got]); // R3

    AST_ACK_MASKS: assert property (@(posedge clk) disable iff (rst)
        evt_hit |=> mask_q[$past(got)]); // R3

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
        evt_hit |-> ((col_live & below) == '0)); // R4

    AST_PENDING_SRC: assert property (@(posedge clk) disable iff (rst)
        evt_hit |-> (line_in[got] || req_q[got])); // R5

    AST_ROUTED_ONLY: assert property (@(posedge clk) disable iff (rst)
        evt_hit |-> route_q[got][bus_cpu]); // R7

    AST_INFO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_INFO) |-> (bus_rdata == DATA_W'(NL))); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 16'h0000) |-> (bus_rdata == '0)); // R9

endmodule

bind prio_irq_ctrl prio_irq_chk #(.NL(NUM_LINES), .NC(NUM_CPUS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_in   (line_in),
    .bus_cpu   (bus_cpu),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .mask_q    (mask_q),
    .req_q     (req_q),
    .route_q   (route_q)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] line_in = '0;
    logic [1:0]  bus_cpu = '0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad = 0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    prio_irq_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .bus_cpu   (bus_cpu),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata)
    );

    typedef struct packed {
        logic        is_rd;
        logic [1:0]  cpu;
        logic [15:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 16'h2004, 32'h0,   32'h0,        4'd2}, // R2 all masked
        '{1'b1, 2'd2, 16'h2000, 32'h0,   32'h2,        4'd8}, // R8 who-am-i
        '{1'b1, 2'd1, 16'h0004, 32'h0,   32'd64,       4'd8}, // R8 line count
        '{1'b1, 2'd0, 16'h4100, 32'h0,   32'hFFFFFFFF, 4'd1}, // R1 mask word 0
        '{1'b1, 2'd0, 16'h4104, 32'h0,   32'hFFFFFFFF, 4'd1}, // R1 mask word 1
        '{1'b1, 2'd0, 16'h4000, 32'h0,   32'h0,        4'd1}, // R1 requests clear
        '{1'b1, 2'd0, 16'h3094, 32'h0,   32'h1,        4'd1}, // R1 route of line 37
        '{1'b0, 2'd0, 16'h4000, 32'h120, 32'h0,        4'd5}, // R5 request lines 5, 8
        '{1'b1, 2'd0, 16'h2004, 32'h0,   32'h0,        4'd6}, // R6 still masked
        '{1'b1, 2'd0, 16'h4000, 32'h0,   32'h120,      4'd5}, // R5 readback
        '{1'b0, 2'd0, 16'h4180, 32'h100, 32'h0,        4'd6}, // R6 unmask 8
        '{1'b1, 2'd0, 16'h4100, 32'h0,   32'hFFFFFEFF, 4'd6}, // R6 only bit 8 cleared
        '{1'b0, 2'd0, 16'h4180, 32'h20,  32'h0,        4'd6}, // R6 unmask 5
        '{1'b1, 2'd0, 16'h2004, 32'h0,   32'h00010005, 4'd4}, // R4 line 5 before 8
        '{1'b1, 2'd0, 16'h2004, 32'h0,   32'h00010008, 4'd3}, // R3 5 acked, 8 next
        '{1'b1, 2'd0, 16'h2004, 32'h0,   32'h0,        4'd3}, // R3 both acked
        '{1'b1, 2'd0, 16'h4180, 32'h0,   32'hFFFFFFFF, 4'd3}, // R3 masks set again
        '{1'b0, 2'd0, 16'h30A0, 32'h4,   32'h0,        4'd7}, // R7 line 40 to cpu 2
        '{1'b1, 2'd3, 16'h30A0, 32'h0,   32'h4,        4'd7}, // R7 route readback
        '{1'b0, 2'd0, 16'h4004, 32'h100, 32'h0,        4'd5}, // R5 request line 40
        '{1'b0, 2'd0, 16'h4184, 32'h100, 32'h0,        4'd6}, // R6 unmask line 40
        '{1'b1, 2'd0, 16'h2004, 32'h0,   32'h0,        4'd7}, // R7 cpu 0 not routed
        '{1'b1, 2'd2, 16'h2004, 32'h0,   32'h00010028, 4'd7}, // R7 cpu 2 gets 40
        '{1'b1, 2'd2, 16'h4104, 32'h0,   32'hFFFFFFFF, 4'd3}, // R3 line 40 masked
        '{1'b0, 2'd0, 16'h4084, 32'h100, 32'h0,        4'd5}, // R5 clear request 40
        '{1'b1, 2'd0, 16'h4004, 32'h0,   32'h0,        4'd5}, // R5 cleared
        '{1'b0, 2'd0, 16'h0100, 32'hFFFF, 32'h0,       4'd9}, // R9 unmapped write
        '{1'b1, 2'd0, 16'h0100, 32'h0,   32'h0,        4'd9}  // R9 unmapped read
    };

    task automatic bus_write(input logic [1:0] c, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_cpu   = c;
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] c, input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_cpu  = c;
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic read_check(input string req, input logic [1:0] c, input logic [15:0] a,
                              input logic [31:0] exp);
        logic [31:0] d;
        bus_read(c, a, d);
        check(req, d, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_rd)
                read_check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].cpu, VEC[i].addr, VEC[i].exp);
            else
                bus_write(VEC[i].cpu, VEC[i].addr, VEC[i].data);
        end

        // R5: a hardware input alone makes line 63 pending
        line_in[63] = 1'b1;
        bus_write(2'd0, 16'h4184, 32'h80000000);
        read_check("R7 line63 not for cpu1", 2'd1, 16'h2004, 32'h0);
        read_check("R5 hw line 63", 2'd0, 16'h2004, 32'h0001003F);
        read_check("R3 line 63 acked while input high", 2'd0, 16'h2004, 32'h0);

        // R4: software line 3 beats hardware line 10
        line_in[10] = 1'b1;
        bus_write(2'd0, 16'h4000, 32'h8);
        bus_write(2'd0, 16'h4180, 32'h408);
        read_check("R4 line 3 first", 2'd0, 16'h2004, 32'h00010003);
        read_check("R4 line 10 second", 2'd0, 16'h2004, 32'h0001000A);
        read_check("R3 nothing left", 2'd0, 16'h2004, 32'h0);

        // R9: just past the mask-clear window is unmapped
        bus_write(2'd0, 16'h4188, 32'hFFFFFFFF);
        read_check("R9 mask untouched", 2'd0, 16'h4100, 32'hFFFFFFFF);
        read_check("R9 read past window", 2'd0, 16'h4188, 32'h0);

        // R1: reset in mid-run restores defaults
        bus_write(2'd0, 16'h3004, 32'h8);
        bus_write(2'd0, 16'h4180, 32'h1);
        bus_write(2'd0, 16'h4000, 32'h1);
        @(negedge clk) rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        read_check("R1 route reset", 2'd0, 16'h3004, 32'h1);
        read_check("R1 mask reset", 2'd0, 16'h4100, 32'hFFFFFFFF);
        read_check("R1 request reset", 2'd0, 16'h4080, 32'h0);
        read_check("R2 idle after reset", 2'd0, 16'h2004, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule